// File: doc/BRIEF.md
# Machine-check error reporting bank

This block gathers hardware error reports from one group of functional units and keeps them in a small architectural record: a status word (valid, overflow, uncorrected, context-corrupt, address-valid and a type code) and a separate address register. One error event may arrive per clock. The block also decides whether an event should raise a machine-check exception. When it should, the block sends a one-cycle request to the exception logic.

Logging and signalling are kept apart. The control enable vector has one bit per error-type code. It gates only the exception request, so errors are recorded even when every enable bit is zero. Once an uncorrected error is held, that record is locked. Later errors only mark overflow, so the handler always sees the first fatal fault and its own address. Software clears the record by writing zero to status. An error arriving in the same cycle as that write is logged on top of the cleared record.

Top module: `mc_err_bank`

## Requirements
- R1: After reset, every status field is zero, the address register is zero and the exception request is low.
- R2: An error event that arrives while no record is valid writes the record in the next cycle: valid becomes 1, overflow stays 0, and the type code is copied from the event.
- R3: Any error event that arrives while the record is valid sets overflow in the next cycle. This includes two back-to-back reports from the two halves of one access.
- R4: A logged uncorrected error sets both the uncorrected bit and the context-corrupt bit. A logged corrected error leaves the uncorrected bit at 0 and copies the event's context-corrupt flag.
- R5: While the uncorrected bit is set, later events change no field except overflow: the type code, the uncorrected, context-corrupt and address-valid bits, and the address all stay the same.
- R6: A corrected or uncorrected event replaces a held corrected record. It updates the type code, the class bits and the address-valid bit.
- R7: The address-valid bit follows the event's address-valid flag on every update. The address register is loaded only by an updating event whose address is valid, and holds its value otherwise.
- R8: The exception request is high for exactly the one cycle after an uncorrected error is logged, and only when the control bit indexed by that error's type code is 1. It is never raised for a corrected error, or for an error that does not update the record.
- R9: With the whole control vector at zero, uncorrected errors are still logged in full, but no exception request is raised.
- R10: The clear strobe drops valid, overflow, uncorrected, context-corrupt and address-valid in the next cycle. An event in the same cycle is logged as if the record were already empty, with overflow 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Error event present this cycle |
| evt_uncorr | input | 1 | 1 = uncorrected, 0 = corrected |
| evt_pcc | input | 1 | Source reports context corrupted |
| evt_addr_valid | input | 1 | evt_addr carries a meaningful address |
| evt_addr | input | ADDR_W | Physical address of the faulting access |
| evt_code | input | 4 | Error-type code |
| ctl_en | input | 16 | Per-type exception enable, bit n for code n |
| sw_clr | input | 1 | Software write of zero to status |
| stat_valid | output | 1 | Record valid |
| stat_ovf | output | 1 | Further error seen while record valid |
| stat_uncorr | output | 1 | Held error is uncorrected |
| stat_pcc | output | 1 | Processor context corrupt |
| stat_addrv | output | 1 | Address register is meaningful |
| stat_code | output | 4 | Logged error-type code |
| addr_out | output | ADDR_W | Logged physical address |
| mce_req | output | 1 | One-cycle exception request |

## Verification
A wrong lock state shows at the ports one cycle after the next event. The type code or address changes under a held uncorrected record, or a second exception pulse appears. A missed overflow update shows as stat_ovf staying low on the cycle after a second event. Address-register corruption shows up as soon as a non-updating event carries a different address. For that reason the random stimulus gives every event a fresh address, and the bench compares every output on every cycle against a reference record.

// File: rtl/mc_bank_pkg.sv
package mc_bank_pkg;
    localparam int unsigned MC_CODE_W  = 4;
    localparam int unsigned MC_N_TYPES = 1 << MC_CODE_W;

    typedef struct packed {
        logic                 valid;
        logic                 ovf;
        logic                 uncorr;
        logic                 pcc;
        logic                 addrv;
        logic [MC_CODE_W-1:0] code;
    } mc_stat_t;

    localparam mc_stat_t MC_STAT_RESET = '0;
endpackage

// File: rtl/mc_evt_classify.sv
module mc_evt_classify
    import mc_bank_pkg::*;
(
    input  logic                  evt_uncorr,
    input  logic                  evt_pcc,
    input  logic [MC_CODE_W-1:0]  evt_code,
    input  logic [MC_N_TYPES-1:0] ctl_en,
    output logic                  pcc_bit,
    output logic                  type_en
);
    logic [MC_N_TYPES-1:0] code_hot;

    // one-hot decode of the type code, then AND-OR with the enable vector
    for (genvar g = 0; g < MC_N_TYPES; g++) begin : g_dec
        assign code_hot[g] = (evt_code == MC_CODE_W'(g));
    end

    always_comb begin
        pcc_bit = evt_uncorr | evt_pcc;
        type_en = |(code_hot & ctl_en);
    end
endmodule

// File: rtl/mc_status_log.sv
module mc_status_log
    import mc_bank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_valid,
    input  logic                 evt_uncorr,
    input  logic                 pcc_bit,
    input  logic                 evt_addr_valid,
    input  logic [MC_CODE_W-1:0] evt_code,
    input  logic                 sw_clr,
    output mc_stat_t             stat_q,
    output logic                 upd
);
    mc_stat_t stat_d;
    mc_stat_t base;

    always_comb begin
        base = stat_q;
        if (sw_clr) begin
            base.valid  = 1'b0;
            base.ovf    = 1'b0;
            base.uncorr = 1'b0;
            base.pcc    = 1'b0;
            base.addrv  = 1'b0;
        end
        stat_d = base;
        upd    = evt_valid && !base.uncorr;
        if (evt_valid && base.valid) begin
            stat_d.ovf = 1'b1;
        end
        if (upd) begin
            stat_d.valid  = 1'b1;
            stat_d.uncorr = evt_uncorr;
            stat_d.pcc    = pcc_bit;
            stat_d.addrv  = evt_addr_valid;
            stat_d.code   = evt_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= MC_STAT_RESET;
        else        stat_q <= stat_d;
    end

    // R3: a second event while valid must set overflow
    p_ovf_on_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !sw_clr && stat_q.valid) |=> stat_q.ovf);

    // R5: a held uncorrected record is locked
    p_uncorr_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !sw_clr && stat_q.uncorr)
        |=> (stat_q.uncorr && $stable(stat_q.code) && $stable(stat_q.addrv)));

    // R4: uncorrected always comes with context corrupt
    p_uncorr_pcc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q.uncorr |-> (stat_q.pcc && stat_q.valid));

    // R10: a lone clear empties the record
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr && !evt_valid) |=> (!stat_q.valid && !stat_q.ovf && !stat_q.uncorr));
endmodule

// File: rtl/mc_addr_hold.sv
module mc_addr_hold #(
    parameter int unsigned ADDR_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_q
);
    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        addr_d = wr_en ? addr_in : addr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    // R7: the address is held unless a logging event writes it
    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(addr_q));
endmodule

// File: rtl/mc_err_bank.sv
module mc_err_bank
    import mc_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 36
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  evt_valid,
    input  logic                  evt_uncorr,
    input  logic                  evt_pcc,
    input  logic                  evt_addr_valid,
    input  logic [ADDR_W-1:0]     evt_addr,
    input  logic [MC_CODE_W-1:0]  evt_code,
    input  logic [MC_N_TYPES-1:0] ctl_en,
    input  logic                  sw_clr,
    output logic                  stat_valid,
    output logic                  stat_ovf,
    output logic                  stat_uncorr,
    output logic                  stat_pcc,
    output logic                  stat_addrv,
    output logic [MC_CODE_W-1:0]  stat_code,
    output logic [ADDR_W-1:0]     addr_out,
    output logic                  mce_req
);
    logic     pcc_bit;
    logic     type_en;
    logic     upd;
    mc_stat_t stat_q;
    logic     mce_d;
    logic     mce_q;

    mc_evt_classify u_classify (
        .evt_uncorr (evt_uncorr),
        .evt_pcc    (evt_pcc),
        .evt_code   (evt_code),
        .ctl_en     (ctl_en),
        .pcc_bit    (pcc_bit),
        .type_en    (type_en)
    );

    mc_status_log u_log (
        .clk            (clk),
        .rst_n          (rst_n),
        .evt_valid      (evt_valid),
        .evt_uncorr     (evt_uncorr),
        .pcc_bit        (pcc_bit),
        .evt_addr_valid (evt_addr_valid),
        .evt_code       (evt_code),
        .sw_clr         (sw_clr),
        .stat_q         (stat_q),
        .upd            (upd)
    );

    mc_addr_hold #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (upd && evt_addr_valid),
        .addr_in (evt_addr),
        .addr_q  (addr_out)
    );

    // request only for a logged uncorrected error of an enabled type
    always_comb begin
        mce_d = upd && evt_uncorr && type_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mce_q <= 1'b0;
        else        mce_q <= mce_d;
    end

    always_comb begin
        stat_valid  = stat_q.valid;
        stat_ovf    = stat_q.ovf;
        stat_uncorr = stat_q.uncorr;
        stat_pcc    = stat_q.pcc;
        stat_addrv  = stat_q.addrv;
        stat_code   = stat_q.code;
        mce_req     = mce_q;
    end

    // R8: a request means an uncorrected error of an enabled type arrived last cycle
    p_mce_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mce_req |-> ($past(evt_valid && evt_uncorr && ctl_en[evt_code]) && stat_uncorr));

    // R9: with no type enabled, no request follows
    p_mce_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_en == '0) |=> !mce_req);
endmodule

// File: tb/mc_err_bank_tb.sv
module mc_err_bank_tb;
    localparam int AW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          evt_valid = 0, evt_uncorr = 0, evt_pcc = 0, evt_addr_valid = 0;
    logic [AW-1:0] evt_addr = '0;
    logic [3:0]    evt_code = '0;
    logic [15:0]   ctl_en = '0;
    logic          sw_clr = 0;
    logic          stat_valid, stat_ovf, stat_uncorr, stat_pcc, stat_addrv, mce_req;
    logic [3:0]    stat_code;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int fails  = 0;

    // reference record
    logic          m_valid, m_ovf, m_uncorr, m_pcc, m_addrv, m_mce;
    logic [3:0]    m_code;
    logic [AW-1:0] m_addr;

    always #10 clk = ~clk;

    mc_err_bank #(.ADDR_W(AW)) u_dut (.*);

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R2", "valid",  stat_valid,  m_valid);
        chk("R3", "ovf",    stat_ovf,    m_ovf);
        chk("R4", "uncorr", stat_uncorr, m_uncorr);
        chk("R4", "pcc",    stat_pcc,    m_pcc);
        chk("R7", "addrv",  stat_addrv,  m_addrv);
        chk("R5/R6", "code", stat_code,  m_code);
        chk("R7", "addr",   addr_out,    m_addr);
        chk("R8", "mce",    mce_req,     m_mce);
    endtask

    function automatic logic model_upd(input logic clr);
        return evt_valid && !(m_uncorr && !clr);
    endfunction

    // drive at negedge, step model, compare 5 ns after the posedge
    task automatic step(input logic ev, input logic u, input logic p, input logic av,
                        input logic [AW-1:0] a, input logic [3:0] c,
                        input logic [15:0] ctl, input logic clr);
        logic up;
        @(negedge clk);
        evt_valid = ev; evt_uncorr = u; evt_pcc = p; evt_addr_valid = av;
        evt_addr = a; evt_code = c; ctl_en = ctl; sw_clr = clr;
        up = model_upd(clr);
        if (clr) begin
            m_valid = 0; m_ovf = 0; m_uncorr = 0; m_pcc = 0; m_addrv = 0;
        end
        if (ev && m_valid) m_ovf = 1;
        if (up) begin
            m_valid = 1; m_uncorr = u; m_pcc = u | p; m_addrv = av; m_code = c;
            if (av) m_addr = a;
        end
        m_mce = up && u && ctl[c];
        @(posedge clk);
        #5;
        check_all();
    endtask

    task automatic idle();
        step(0, 0, 0, 0, '0, 4'h0, 16'hFFFF, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        r = $urandom(32'h5EED_2024);
        m_valid = 0; m_ovf = 0; m_uncorr = 0; m_pcc = 0; m_addrv = 0;
        m_mce = 0; m_code = 0; m_addr = 0;
        repeat (3) @(posedge clk);
        #5;
        // R1 reset state
        chk("R1", "reset valid", stat_valid, 0);
        chk("R1", "reset ovf",   stat_ovf,   0);
        chk("R1", "reset addr",  addr_out,   0);
        chk("R1", "reset mce",   mce_req,    0);
        @(negedge clk);
        rst_n = 1;

        // R2/R4 corrected error into empty record
        step(1, 0, 1, 1, 36'h1_0000_0040, 4'h3, 16'hFFFF, 0);
        chk("R2", "first log ovf clear", stat_ovf, 0);
        // R3 second half of same access -> overflow, corrected replaces (R6)
        step(1, 0, 0, 1, 36'h1_0000_0080, 4'h3, 16'hFFFF, 0);
        chk("R3", "second half overflow", stat_ovf, 1);
        chk("R6", "corrected replaced addr", addr_out, 36'h1_0000_0080);
        // R6 uncorrected replaces corrected, R8 pulse
        step(1, 1, 0, 1, 36'h2_0000_1000, 4'h5, 16'h0020, 0);
        chk("R8", "pulse on enabled uncorr", mce_req, 1);
        idle();
        chk("R8", "pulse lasts one cycle", mce_req, 0);
        // R5 later errors do not replace the held uncorrected record
        step(1, 1, 0, 1, 36'h3_0000_2000, 4'h5, 16'hFFFF, 0);
        chk("R5", "addr kept", addr_out, 36'h2_0000_1000);
        chk("R8", "no pulse on locked record", mce_req, 0);
        step(1, 0, 0, 1, 36'h4_0000_3000, 4'h9, 16'hFFFF, 0);
        chk("R5", "code kept", stat_code, 4'h5);
        // R10 clear with simultaneous event
        step(1, 0, 0, 0, 36'h5_0000_0000, 4'hA, 16'hFFFF, 1);
        chk("R10", "event after clear ovf", stat_ovf, 0);
        chk("R10", "event after clear uncorr", stat_uncorr, 0);
        chk("R7", "addr held when addr invalid", addr_out, 36'h2_0000_1000);
        step(0, 0, 0, 0, '0, 4'h0, 16'hFFFF, 1);
        chk("R10", "clear valid", stat_valid, 0);
        // R9 masked signalling still logs
        step(1, 1, 0, 1, 36'h6_0000_0100, 4'hC, 16'h0000, 0);
        chk("R9", "masked still logs uncorr", stat_uncorr, 1);
        chk("R9", "masked no pulse", mce_req, 0);
        step(0, 0, 0, 0, '0, 4'h0, 16'hFFFF, 1);
        // R8 enable bit of a different type does not gate
        step(1, 1, 0, 0, '0, 4'h2, 16'hFFFB, 0);
        chk("R8", "other-type enable ignored", mce_req, 0);

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic ev, u, p, av, clr;
            logic [15:0] ctl;
            ev  = ($urandom % 10) < 6;
            u   = ($urandom % 8) == 0;
            p   = ($urandom % 4) == 0;
            av  = ($urandom % 4) != 0;
            clr = ($urandom % 12) == 0;
            ctl = (($urandom % 5) == 0) ? 16'h0 : 16'($urandom);
            step(ev, u, p, av, {4'($urandom), 32'($urandom)}, 4'($urandom), ctl, clr);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule